// File: doc/BRIEF.md
# Truncated Timestamp Width Extender

The datapath reports event times as the low 40 bits of a free-running nanosecond counter. This block turns each such short stamp into a full 64-bit nanosecond time. It does this with two stored values. The first is a cached copy of the counter's upper 32-bit word, which an outside scheduler refreshes from time to time. The second is a signed 64-bit correction that software writes whenever it wants to move the reported time without stepping the counter itself.

The cache keeps a value 16 units lower than the sampled word. Each unit is 2^32 ns, so the cache runs about a minute behind live time. Because of that lag, every stamp that arrives is later than the cached time, and the 8 bits where the cache and the stamp overlap only need to be resolved in one direction: a forward carry into the upper cache bits. The extended time is registered and appears one cycle after the stamp. A staleness flag rises when refreshes stop arriving for one and a half refresh periods.

Top module: `ts_extender`

## Requirements
- R1: After reset the cached word and the offset are both zero, `ext_valid` and `refresh_late` are low, and `ext_time` is zero. A stamp sampled before any refresh or offset write comes out equal to the stamp, zero-extended.
- R2: A refresh strobe stores `refresh_word - 16` (modulo 2^32) as the cached word. Without a strobe the cached word is held.
- R3: When stamp bits 39:32 are greater than or equal to cached bits 7:0, result bits 63:40 equal cached bits 31:8. Result bits 39:0 always equal the stamp before the offset is added.
- R4: When stamp bits 39:32 are less than cached bits 7:0, result bits 63:40 equal cached bits 31:8 plus one, modulo 2^24. This is a forward wrap of the 40-bit field.
- R5: The signed two's-complement offset is added modulo 2^64. A write is used by stamps sampled on later edges. A stamp sampled on the same edge as the write uses the previous offset.
- R6: `ext_valid` is high exactly in the cycle after a sampled `stamp_valid`. `ext_time` changes only then. Refresh strobes and offset writes on their own give no output pulse.
- R7: A stamp sampled on the same edge as a refresh is extended with the cached word from before that refresh.
- R8: `refresh_late` rises once REFRESH_CYCLES*3/2 edges have passed since the last refresh (or since reset) with no refresh strobe. It falls on the edge that samples a refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stamp_valid | input | 1 | Truncated stamp present |
| stamp_lo | input | 40 | Low 40 bits of the nanosecond count |
| refresh_valid | input | 1 | Refresh the cached upper word |
| refresh_word | input | 32 | Sampled counter bits 63:32 |
| offset_wr | input | 1 | Load a new time offset |
| offset_val | input | 64 | Signed offset in nanoseconds |
| ext_valid | output | 1 | Extended time present |
| ext_time | output | 64 | Extended time plus offset |
| refresh_late | output | 1 | No refresh within 1.5 periods |

## Verification
The assertions check properties that hold on every cycle. The cache must load the strobed word minus the lag and hold otherwise. An output pulse must follow every accepted stamp and nothing else, and the output must stay steady between pulses. After the offset is taken away, the result must carry the stamp bits unchanged and an upper part within one step of the cached word. A refresh must clear the late flag. Only the bench scenarios can show that the carry is taken on the correct side of the overlap boundary. The same holds for the wrap of the cache on a refresh below 16, and for signed offsets working out to the right full value. Same-edge ordering against refresh and offset writes, and the exact edge on which the late flag rises, likewise depend on the bench scenarios.

// File: rtl/tse_pkg.sv
package tse_pkg;

    localparam int TIME_W = 64;                 // full time width
    localparam int STAMP_W = 40;                // truncated stamp width
    localparam int WORD_W = 32;                 // cached upper word width
    localparam int OVL_W = STAMP_W - (TIME_W - WORD_W);   // overlap bits
    localparam int UP_W = WORD_W - OVL_W;       // bits above the stamp

    typedef logic [TIME_W-1:0]  time_t;
    typedef logic [STAMP_W-1:0] stamp_t;
    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [UP_W-1:0]    upper_t;
    typedef logic [OVL_W-1:0]   ovl_t;

    typedef struct packed {
        logic   vld;
        stamp_t stamp;
    } stamp_beat_t;

    typedef struct packed {
        logic  vld;
        time_t t;
    } time_beat_t;

    // Upper bits of the rebuilt time: carry once if the stamp's overlap
    // byte sits below the cache's, meaning the 40-bit field wrapped.
    function automatic upper_t rebuild_upper(word_t cache, stamp_t stamp);
        ovl_t c_ovl;
        ovl_t s_ovl;
        c_ovl = cache[OVL_W-1:0];
        s_ovl = stamp[STAMP_W-1:STAMP_W-OVL_W];
        return cache[WORD_W-1:OVL_W] + upper_t'(s_ovl < c_ovl);
    endfunction

    function automatic time_t rebuild_time(word_t cache, stamp_t stamp);
        return {rebuild_upper(cache, stamp), stamp};
    endfunction

endpackage

// File: rtl/tse_hi_cache.sv
module tse_hi_cache
    import tse_pkg::*;
#(
    parameter int LAG = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  refresh_valid,
    input  word_t refresh_word,
    output word_t cache_o
);

    localparam word_t LAG_W = word_t'(LAG);

    word_t cache_q;

    always_ff @(posedge clk) begin
        if (rst)
            cache_q <= '0;
        else if (refresh_valid)
            cache_q <= refresh_word - LAG_W;
    end

    assign cache_o = cache_q;

    AST_CACHE_LOAD: assert property (@(posedge clk) disable iff (rst)
        refresh_valid |=> (cache_o + LAG_W) == $past(refresh_word)); // R2
    AST_CACHE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !refresh_valid |=> $stable(cache_o)); // R2

endmodule

// File: rtl/tse_ofs_reg.sv
module tse_ofs_reg
    import tse_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr,
    input  time_t val,
    output time_t ofs_o
);

    time_t ofs_q;

    always_ff @(posedge clk) begin
        if (rst)
            ofs_q <= '0;
        else if (wr)
            ofs_q <= val;
    end

    assign ofs_o = ofs_q;

    AST_OFS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(ofs_o)); // R5

endmodule

// File: rtl/tse_stale_mon.sv
module tse_stale_mon #(
    parameter longint unsigned REFRESH_CYCLES = 64'd13743895347
) (
    input  logic clk,
    input  logic rst,
    input  logic refresh_valid,
    output logic late_o
);

    localparam longint unsigned LIMIT = REFRESH_CYCLES + REFRESH_CYCLES / 2;
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);

    logic [CNT_W-1:0] age_q;

    always_ff @(posedge clk) begin
        if (rst || refresh_valid)
            age_q <= '0;
        else if (age_q != LIMIT_C)
            age_q <= age_q + 1'b1;
    end

    assign late_o = (age_q == LIMIT_C);

    AST_LATE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        refresh_valid |=> !late_o); // R8
    AST_LATE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (late_o && !refresh_valid) |=> late_o); // R8

endmodule

// File: rtl/tse_merge.sv
module tse_merge
    import tse_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  stamp_beat_t in_beat,
    input  word_t       cache_i,
    input  time_t       ofs_i,
    output time_beat_t  out_beat
);

    time_t      base_c;
    time_beat_t out_q;

    always_comb begin
        base_c = rebuild_time(cache_i, in_beat.stamp);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.vld <= in_beat.vld;
            if (in_beat.vld)
                out_q.t <= base_c + ofs_i;
        end
    end

    assign out_beat = out_q;

    AST_STAMP_PASS: assert property (@(posedge clk) disable iff (rst)
        in_beat.vld |=> STAMP_W'(out_beat.t - $past(ofs_i)) == $past(in_beat.stamp)); // R3
    AST_CARRY_STEP: assert property (@(posedge clk) disable iff (rst)
        in_beat.vld |=> (upper_t'((out_beat.t - $past(ofs_i)) >> STAMP_W)
                         - $past(cache_i[WORD_W-1:OVL_W])) <= upper_t'(1)); // R4

endmodule

// File: rtl/ts_extender.sv
module ts_extender
    import tse_pkg::*;
#(
    parameter int LAG = 16,
    parameter longint unsigned REFRESH_CYCLES = 64'd13743895347
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                stamp_valid,
    input  logic [STAMP_W-1:0]  stamp_lo,
    input  logic                refresh_valid,
    input  logic [WORD_W-1:0]   refresh_word,
    input  logic                offset_wr,
    input  logic [TIME_W-1:0]   offset_val,
    output logic                ext_valid,
    output logic [TIME_W-1:0]   ext_time,
    output logic                refresh_late
);

    word_t       cache_w;
    time_t       ofs_w;
    stamp_beat_t beat_in;
    time_beat_t  beat_out;

    assign beat_in.vld   = stamp_valid;
    assign beat_in.stamp = stamp_lo;

    tse_hi_cache #(.LAG(LAG)) u_cache (
        .clk           (clk),
        .rst           (rst),
        .refresh_valid (refresh_valid),
        .refresh_word  (refresh_word),
        .cache_o       (cache_w)
    );

    tse_ofs_reg u_ofs (
        .clk   (clk),
        .rst   (rst),
        .wr    (offset_wr),
        .val   (offset_val),
        .ofs_o (ofs_w)
    );

    tse_stale_mon #(.REFRESH_CYCLES(REFRESH_CYCLES)) u_stale (
        .clk           (clk),
        .rst           (rst),
        .refresh_valid (refresh_valid),
        .late_o        (refresh_late)
    );

    tse_merge u_merge (
        .clk      (clk),
        .rst      (rst),
        .in_beat  (beat_in),
        .cache_i  (cache_w),
        .ofs_i    (ofs_w),
        .out_beat (beat_out)
    );

    assign ext_valid = beat_out.vld;
    assign ext_time  = beat_out.t;

    AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        stamp_valid |=> ext_valid); // R6
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !stamp_valid |=> !ext_valid); // R6
    AST_OUT_STEADY: assert property (@(posedge clk) disable iff (rst)
        !stamp_valid |=> $stable(ext_time)); // R6

endmodule

// File: tb/sim_ts_extender.sv
`timescale 1ns/1ps
module sim_ts_extender;

    localparam longint unsigned RC = 20;
    localparam int LATE_AT = 30;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stamp_valid = 1'b0;
    logic [39:0] stamp_lo = '0;
    logic        refresh_valid = 1'b0;
    logic [31:0] refresh_word = '0;
    logic        offset_wr = 1'b0;
    logic [63:0] offset_val = '0;
    logic        ext_valid;
    logic [63:0] ext_time;
    logic        refresh_late;

    int checks = 0;
    int errors = 0;

    logic [63:0] m_ofs = '0;
    logic [63:0] live = '0;

    always #2.5 clk = ~clk;

    ts_extender #(.LAG(16), .REFRESH_CYCLES(RC)) u0 (
        .clk(clk), .rst(rst),
        .stamp_valid(stamp_valid), .stamp_lo(stamp_lo),
        .refresh_valid(refresh_valid), .refresh_word(refresh_word),
        .offset_wr(offset_wr), .offset_val(offset_val),
        .ext_valid(ext_valid), .ext_time(ext_time),
        .refresh_late(refresh_late)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // true time minus nothing: requirement-level expectation
    function automatic logic [63:0] expect_time(logic [63:0] t_true, logic [63:0] ofs);
        return t_true + ofs;
    endfunction

    task automatic send_stamp(string req, logic [39:0] s, logic [63:0] exp);
        stamp_valid = 1'b1;
        stamp_lo = s;
        @(negedge clk);
        stamp_valid = 1'b0;
        chk({req, " valid"}, 64'(ext_valid), 64'd1);
        chk(req, ext_time, exp);
        @(negedge clk);
        chk("R6 single pulse", 64'(ext_valid), 64'd0);
    endtask

    task automatic do_refresh(logic [31:0] w);
        refresh_valid = 1'b1;
        refresh_word = w;
        @(negedge clk);
        refresh_valid = 1'b0;
        chk("R6 no pulse on refresh", 64'(ext_valid), 64'd0);
    endtask

    task automatic do_offset(logic [63:0] v);
        offset_wr = 1'b1;
        offset_val = v;
        @(negedge clk);
        offset_wr = 1'b0;
        m_ofs = v;
        chk("R6 no pulse on offset write", 64'(ext_valid), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0017));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset valid", 64'(ext_valid), 64'd0);
        chk("R1 reset late", 64'(refresh_late), 64'd0);
        chk("R1 reset time", ext_time, 64'd0);

        // R1: no refresh yet, zero cache and offset
        send_stamp("R1 unrefreshed", 40'h12_3456_789A, 64'h0000_0012_3456_789A);

        // R2/R3/R4: cache 0xF0 after refresh 0x100
        do_refresh(32'h0000_0100);
        send_stamp("R3 no carry", 40'hF5_0000_0000, 64'h0000_00F5_0000_0000);
        send_stamp("R4 wrap 2^40", 40'h02_0000_0010, 64'h0000_0102_0000_0010);

        // lag boundary: cache 0x12345668
        do_refresh(32'h1234_5678);
        send_stamp("R3 equal byte", 40'h68_0000_0000, 64'h1234_5668_0000_0000);
        send_stamp("R4 byte below", 40'h67_0000_0000, 64'h1234_5767_0000_0000);

        // R2 wrap on a small refresh word: cache 0xFFFFFFF5
        do_refresh(32'h0000_0005);
        send_stamp("R4 carry wraps upper", 40'h03_0000_0001, 64'h0000_0003_0000_0001);
        send_stamp("R2 cache wrapped", 40'hF6_0000_0002, 64'hFFFF_FFF6_0000_0002);

        // R5: positive and negative offsets, cache 0xF0
        do_refresh(32'h0000_0100);
        do_offset(64'd1000);
        send_stamp("R5 positive offset", 40'hF5_0000_0000, 64'h0000_00F5_0000_03E8);
        do_offset(-64'sd16);
        send_stamp("R5 negative offset", 40'h02_0000_0000, 64'h0000_0101_FFFF_FFF0);

        // R5: offset write on the same edge as a stamp uses old offset
        offset_wr = 1'b1; offset_val = 64'd7;
        stamp_valid = 1'b1; stamp_lo = 40'hF5_0000_0000;
        @(negedge clk);
        offset_wr = 1'b0; stamp_valid = 1'b0; m_ofs = 64'd7;
        chk("R5 same edge old offset", ext_time, 64'h0000_00F4_FFFF_FFF0);
        do_offset(64'd0);

        // R7: refresh and stamp on one edge: old cache 0xF0 applies
        refresh_valid = 1'b1; refresh_word = 32'h0000_0005;
        stamp_valid = 1'b1; stamp_lo = 40'h02_0000_0000;
        @(negedge clk);
        refresh_valid = 1'b0; stamp_valid = 1'b0;
        chk("R7 old cache used", ext_time, 64'h0000_0102_0000_0000);
        send_stamp("R7 new cache after", 40'h02_0000_0000, 64'h0000_0002_0000_0000);

        // R8: lateness timing
        do_refresh(32'h0000_0100);
        repeat (LATE_AT - 1) @(negedge clk);
        chk("R8 not yet late", 64'(refresh_late), 64'd0);
        @(negedge clk);
        chk("R8 late", 64'(refresh_late), 64'd1);
        do_refresh(32'h0000_0100);
        chk("R8 cleared", 64'(refresh_late), 64'd0);

        // random: true counter C, refresh with C[63:32], stamps at C + d
        live = {$urandom, $urandom};
        do_refresh(live[63:32]);
        for (int i = 0; i < 400; i++) begin
            int op;
            op = int'($urandom % 6);
            if (op == 0) begin
                live = {$urandom, $urandom};
                do_refresh(live[63:32]);
            end else if (op == 1) begin
                do_offset({$urandom, $urandom});
            end else begin
                logic [63:0] t_true;
                logic [63:0] d;
                d = 64'({$urandom, $urandom} % 64'h10_0000_0000) - 64'h4_0000_0000;
                t_true = live + d;
                send_stamp("R4 random extension", t_true[39:0], expect_time(t_true, m_ofs));
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule